// File: doc/BRIEF.md
# Expander I/O Port with Change Interrupt

This block is an 8-bit general-purpose I/O bank of the kind that sits behind a two-wire serial register interface. A simple parallel register bus programs three writable registers. The direction register sets each pin as an input or an output. The drive register holds the output levels. The invert register flips bits in the data returned when software reads the pins. A fourth, read-only register samples the synchronized pin levels on every read of its address.

The block also compares every pin configured as an input with the value held in the sample register. Any difference drives an enable for an external open-drain, active-low interrupt line. The interrupt clears when the pins return to the sampled value, or when software reads the sample register, because that read takes a new sample. Turning an output back into an input can raise the interrupt at once if the pin level differs from the last sample. This behaviour is kept on purpose.

Top module: `xp_port`

## Requirements
- R1: After synchronous reset the direction register reads 0xFF (all inputs), the drive register reads 0xFF, the invert register reads 0x00, `pin_oe` is 0x00 and `irq_od_en` is 0.
- R2: A write with `bus_wr` high loads `bus_wdata` into the register selected by `bus_addr`: 1 is drive, 2 is invert, 3 is direction. A read of addresses 1 to 3 returns that register on `bus_rdata` one clock after the `bus_rd` strobe.
- R3: A direction bit of 0 makes the pin an output: its `pin_oe` bit is 1 and its `pin_out` bit equals the drive bit. A direction bit of 1 gives `pin_oe` 0 and `pin_out` 0.
- R4: A read of address 0 returns the two-flop-synchronized pin levels XOR the invert register. The same clock edge stores the uninverted levels in the sample register.
- R5: When a pin configured as an input changes so that it differs from the sample register, `irq_od_en` goes high after the second rising clock edge that follows the change, and not after the first.
- R6: A change on a pin configured as an output never raises `irq_od_en`.
- R7: `irq_od_en` falls after the second rising edge once every input pin has returned to its sampled value.
- R8: A read of address 0 drops `irq_od_en` right after the read edge, provided the pins stay stable.
- R9: A write to address 0 is ignored. The drive, invert and direction registers keep their values, and `irq_od_en` is unaffected.
- R10: If a write changes a pin from output to input while its synchronized level differs from the sample register, `irq_od_en` goes high right after that write edge.
- R11: `bus_rdata` keeps its last read value in every cycle that has no read strobe, even across writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 8 | Levels present at the pads |
| pin_out | output | 8 | Level driven on output pins |
| pin_oe | output | 8 | Per-pin output enable |
| irq_od_en | output | 1 | High enables the open-drain pull-down of the interrupt line |

## Verification
A wrong direction bit shows on `pin_oe` one clock after the write. A corrupted sample register shows as a false or missing interrupt on the same cycle it happens, and also as wrong data on the next read of address 0. A broken synchronizer shows up as an interrupt that comes one edge too early or too late after a pin change. The bench therefore samples `irq_od_en` after exactly one edge and after exactly two edges. Corrupted drive or invert state stays hidden until the next readback or pin read, so the bench reads back after every write.

// File: rtl/xp_pkg.sv
package xp_pkg;
    localparam int PORT_W = 8;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_SAMPLE = 2'd0,
        SEL_DRIVE  = 2'd1,
        SEL_INVERT = 2'd2,
        SEL_DIR    = 2'd3
    } xp_sel_e;

    function automatic logic [PORT_W-1:0] xp_read_mux(
        input xp_sel_e           sel,
        input logic [PORT_W-1:0] live,
        input logic [PORT_W-1:0] drive,
        input logic [PORT_W-1:0] invert,
        input logic [PORT_W-1:0] dir
    );
        case (sel)
            SEL_SAMPLE: return live ^ invert;
            SEL_DRIVE:  return drive;
            SEL_INVERT: return invert;
            default:    return dir;
        endcase
    endfunction
endpackage

// File: rtl/xp_sync.sv
module xp_sync #(
    parameter int W = xp_pkg::PORT_W
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        meta_q <= d;
        q      <= meta_q;
    end
endmodule

// File: rtl/xp_regs.sv
module xp_regs
    import xp_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  xp_sel_e      sel,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         rd,
    input  logic [W-1:0] live,
    output logic [W-1:0] drive_q,
    output logic [W-1:0] invert_q,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] sample_q,
    output logic [W-1:0] rdata_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            drive_q  <= '1;
            invert_q <= '0;
            dir_q    <= '1;
            sample_q <= live;
            rdata_q  <= '0;
        end else begin
            if (wr) begin
                case (sel)
                    SEL_DRIVE:  drive_q  <= wdata;
                    SEL_INVERT: invert_q <= wdata;
                    SEL_DIR:    dir_q    <= wdata;
                    default: ;
                endcase
            end
            if (rd) begin
                rdata_q <= xp_read_mux(sel, live, drive_q, invert_q, dir_q);
                if (sel == SEL_SAMPLE) begin
                    sample_q <= live;
                end
            end
        end
    end
endmodule

// File: rtl/xp_irq.sv
module xp_irq #(
    parameter int W = xp_pkg::PORT_W
) (
    input  logic         rst,
    input  logic [W-1:0] live,
    input  logic [W-1:0] sample,
    input  logic [W-1:0] dir,
    output logic         irq
);
    logic [W-1:0] diff;

    always_comb begin
        diff = (live ^ sample) & dir;
        irq  = !rst && (|diff);
    end
endmodule

// File: rtl/xp_port.sv
module xp_port
    import xp_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [W-1:0]      bus_wdata,
    input  logic              bus_rd,
    output logic [W-1:0]      bus_rdata,
    input  logic [W-1:0]      pin_in,
    output logic [W-1:0]      pin_out,
    output logic [W-1:0]      pin_oe,
    output logic              irq_od_en
);
    logic [W-1:0] live;
    logic [W-1:0] drive_q;
    logic [W-1:0] invert_q;
    logic [W-1:0] dir_q;
    logic [W-1:0] sample_q;
    xp_sel_e      sel;

    assign sel = xp_sel_e'(bus_addr);

    xp_sync #(.W(W)) u_sync (
        .clk (clk),
        .d   (pin_in),
        .q   (live)
    );

    xp_regs #(.W(W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .sel      (sel),
        .wr       (bus_wr),
        .wdata    (bus_wdata),
        .rd       (bus_rd),
        .live     (live),
        .drive_q  (drive_q),
        .invert_q (invert_q),
        .dir_q    (dir_q),
        .sample_q (sample_q),
        .rdata_q  (bus_rdata)
    );

    xp_irq #(.W(W)) u_irq (
        .rst    (rst),
        .live   (live),
        .sample (sample_q),
        .dir    (dir_q),
        .irq    (irq_od_en)
    );

    assign pin_oe  = ~dir_q;
    assign pin_out = drive_q & ~dir_q;
endmodule

// File: rtl/xp_port_chk.sv
module xp_port_chk #(
    parameter int W = xp_pkg::PORT_W
) (
    input logic         clk,
    input logic         rst,
    input logic [1:0]   bus_addr,
    input logic         bus_wr,
    input logic [W-1:0] bus_wdata,
    input logic         bus_rd,
    input logic [W-1:0] bus_rdata,
    input logic [W-1:0] pin_oe,
    input logic         irq_od_en,
    input logic [W-1:0] live,
    input logic [W-1:0] drive_q,
    input logic [W-1:0] invert_q,
    input logic [W-1:0] dir_q
);
    AST_RESET_DEFAULTS: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (dir_q == '1 && drive_q == '1 && invert_q == '0 && pin_oe == '0)); // R1

    AST_DIR_TO_OE: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 2'd3) |=> (pin_oe == ~$past(bus_wdata))); // R3

    AST_NO_IRQ_ALL_OUTPUTS: assert property (@(posedge clk) disable iff (rst)
        (dir_q == '0) |-> !irq_od_en); // R6

    AST_READ_CLEARS_IRQ: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == 2'd0) |=> (!irq_od_en || live != $past(live))); // R8

    AST_ADDR0_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 2'd0) |=> ($stable(drive_q) && $stable(invert_q) && $stable(dir_q))); // R9

    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !$past(bus_rd) |-> $stable(bus_rdata)); // R11
endmodule

bind xp_port xp_port_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .pin_oe    (pin_oe),
    .irq_od_en (irq_od_en),
    .live      (live),
    .drive_q   (drive_q),
    .invert_q  (invert_q),
    .dir_q     (dir_q)
);

// File: tb/tb_xp_port.sv
`timescale 1ns/1ps
module tb_xp_port;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in = 8'hA5;
    logic [7:0] pin_out;
    logic [7:0] pin_oe;
    logic       irq_od_en;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } rd_item_t;
    rd_item_t rd_q[$];
    logic     rd_seen = 1'b0;

    always #2.5 clk = ~clk;

    xp_port dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_od_en(irq_od_en)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        tick(1);
        bus_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, input logic [7:0] exp, input string tag);
        rd_item_t it;
        it.exp = exp; it.tag = tag;
        rd_q.push_back(it);
        bus_addr = a; bus_rd = 1'b1;
        tick(1);
        bus_rd = 1'b0;
    endtask

    always @(posedge clk) rd_seen <= bus_rd && !rst;

    always @(negedge clk) begin
        if (rd_seen) begin
            if (rd_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL read: actual 0x%02h expected none", bus_rdata);
            end else begin
                rd_item_t it;
                it = rd_q.pop_front();
                check(it.tag, bus_rdata, it.exp);
            end
        end
    end

    initial begin
        #50000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(5);
        rst = 1'b0;
        tick(1);
        // R1 reset state
        check("R1 irq", {7'd0, irq_od_en}, 8'h00);
        check("R1 oe", pin_oe, 8'h00);
        reg_read(2'd1, 8'hFF, "R1 drive");
        reg_read(2'd2, 8'h00, "R1 invert");
        reg_read(2'd3, 8'hFF, "R1 dir");
        // R4 plain pin read
        reg_read(2'd0, 8'hA5, "R4 read");
        reg_write(2'd2, 8'h0F);
        reg_read(2'd0, 8'hAA, "R4 inverted read");
        reg_read(2'd2, 8'h0F, "R2 invert readback");
        // R2/R3 direction and drive
        reg_write(2'd1, 8'h3C);
        reg_write(2'd3, 8'hF0);
        check("R3 oe", pin_oe, 8'h0F);
        check("R3 out", pin_out, 8'h0C);
        reg_read(2'd3, 8'hF0, "R2 dir readback");
        reg_read(2'd1, 8'h3C, "R2 drive readback");
        // R6 output pin change
        pin_in = 8'hA4;
        tick(3);
        check("R6 irq", {7'd0, irq_od_en}, 8'h00);
        // R5 input pin change, two-edge latency
        pin_in = 8'h24;
        tick(1);
        check("R5 irq after one edge", {7'd0, irq_od_en}, 8'h00);
        tick(1);
        check("R5 irq after two edges", {7'd0, irq_od_en}, 8'h01);
        // R7 pin returns
        pin_in = 8'hA4;
        tick(1);
        check("R7 irq still set", {7'd0, irq_od_en}, 8'h01);
        tick(1);
        check("R7 irq cleared", {7'd0, irq_od_en}, 8'h00);
        // R8 read clears
        pin_in = 8'h24;
        tick(2);
        check("R8 irq set", {7'd0, irq_od_en}, 8'h01);
        reg_read(2'd0, 8'h2B, "R8 read data");
        check("R8 irq cleared by read", {7'd0, irq_od_en}, 8'h00);
        // R9 write to address 0
        reg_write(2'd0, 8'h55);
        check("R9 irq", {7'd0, irq_od_en}, 8'h00);
        reg_read(2'd1, 8'h3C, "R9 drive");
        reg_read(2'd2, 8'h0F, "R9 invert");
        reg_read(2'd3, 8'hF0, "R9 dir");
        // R10 output to input with mismatch
        pin_in = 8'h25;
        tick(3);
        check("R6 irq on output bit0", {7'd0, irq_od_en}, 8'h00);
        reg_write(2'd3, 8'hF1);
        check("R10 irq", {7'd0, irq_od_en}, 8'h01);
        check("R10 oe", pin_oe, 8'h0E);
        // R11 read data hold
        reg_write(2'd1, 8'h81);
        tick(2);
        check("R11 rdata hold", bus_rdata, 8'hF0);
        check("R3 out after drive write", pin_out, 8'h00);
        tick(2);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule